// File: doc/BRIEF.md
# Joystick-and-accelerometer controller poller over I2C

The block is a self-contained I2C master for a handheld game controller that answers at the fixed 7-bit address 0x52. After reset it wakes the device with two short register writes, then repeats a poll forever: it writes the read pointer 0x00, waits a programmed delay, and reads back a six-byte report. It drives SCL itself and pulls SDA low or releases it (open drain). SCL runs at a quarter-phase divide of the system clock, which gives 100 kHz standard mode by default.

Each complete report is split into an 8-bit joystick X and Y, three 10-bit accelerometer axes and two button flags. All these outputs change together, in the same cycle as a one-cycle valid strobe. If the device fails to acknowledge an address or data byte, the transaction ends with a STOP. A sticky error flag is raised, and after a back-off wait the block starts again from the wake-up writes. Clock stretching, multi-master arbitration and report decryption are not handled.

Top module: `joy_poller`

## Requirements
- R1: While reset is held and right after it is released, SCL is high, SDA is released, the valid strobe is 0 and the error flag is 0.
- R2: The first transaction after reset writes address byte 0xA4 (0x52 with write bit 0), then 0xF0 and 0x55, then STOP. The second writes 0xA4, 0xFB, 0x00, then STOP.
- R3: Each poll writes 0xA4 then the single pointer byte 0x00 with a STOP. It waits at least WAIT_CLKS system clocks (and no more than a few quarter periods beyond that). It then starts a read transaction with address byte 0xA5.
- R4: The master reads exactly six bytes. It acknowledges (SDA low) the first five, leaves the sixth unacknowledged (SDA high), and then issues STOP.
- R5: Joystick X equals report byte 0 and joystick Y equals report byte 1.
- R6: Accelerometer X, Y and Z are each 10 bits: {upper byte, 2 low bits}. The upper bytes are report bytes 2, 3 and 4. The low bits come from report byte 5, bits [3:2] for X, [5:4] for Y and [7:6] for Z.
- R7: The button bits in report byte 5 are bit 1 for C and bit 0 for Z, both active low. Each button output is 1 exactly when its bit is 0.
- R8: The valid strobe is high for one cycle per completed six-byte read. The report outputs change only in that cycle and hold their values until the next strobe.
- R9: A missing acknowledge on an address or written byte ends the transaction with STOP and sets the error flag, which stays set until reset. After at least BACKOFF_CLKS clocks, the block restarts from the R2 wake-up writes.
- R10: SDA changes only while SCL is low, except for the START (falling while SCL is high) and STOP (rising while SCL is high) conditions. Input SDA is sampled in the middle of SCL high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_o | output | 1 | I2C clock line |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed level of the SDA line |
| joy_x_o | output | 8 | Joystick X |
| joy_y_o | output | 8 | Joystick Y |
| accel_x_o | output | 10 | Accelerometer X |
| accel_y_o | output | 10 | Accelerometer Y |
| accel_z_o | output | 10 | Accelerometer Z |
| btn_c_o | output | 1 | Button C pressed |
| btn_z_o | output | 1 | Button Z pressed |
| report_vld_o | output | 1 | One-cycle strobe when a new report is on the outputs |
| nack_err_o | output | 1 | Sticky missing-acknowledge flag |

## Verification
A bus-level device model answers the block. It returns all-zero and all-ones reports, which catch stuck or swapped bits, and then a sweep of reports in which the last byte runs through many values. That sweep separates the placement of the three 2-bit low fields from each other and from the two inverted button bits. The model logs every written byte, the STOP positions, the master's acknowledge per read byte and the gap before each read, which tells a correct wake-up and poll order from a shortened or reordered one. A refused pointer-write address, followed by a refused 0xF0 during the re-wake, shows that both address and data rejection abort, back off and restart from the beginning.

// File: rtl/jpoll_pkg.sv
package jpoll_pkg;

    localparam logic [6:0]  JP_DEV   = 7'h52;
    localparam int unsigned JP_LEN   = 6;
    localparam int unsigned JP_RPT_W = 8 * JP_LEN;

    // step indices the sequencer depends on
    localparam logic [3:0] ST_PTR_LAST = 4'd7;
    localparam logic [3:0] ST_RD_ADDR  = 4'd8;
    localparam logic [3:0] ST_RD_LAST  = 4'd14;
    localparam logic [3:0] ST_POLL     = 4'd6;

    typedef struct packed {
        logic       start;
        logic       rd;
        logic       ack;
        logic       stop;
        logic [7:0] data;
    } jp_cmd_t;

    typedef enum logic [1:0] {E_IDLE, E_START, E_BIT, E_STOP} eng_st_t;
    typedef enum logic [2:0] {S_ISSUE, S_BUSY, S_DELAY, S_GAP, S_BACKOFF} seq_st_t;

    // byte-level program: wake-up writes, pointer write, six-byte read
    function automatic jp_cmd_t jp_step_cmd(input logic [3:0] s);
        jp_cmd_t c;
        c = '0;
        case (s)
            4'd0, 4'd3, 4'd6: begin c.start = 1'b1; c.data = {JP_DEV, 1'b0}; end
            4'd1:             c.data = 8'hF0;
            4'd2:             begin c.data = 8'h55; c.stop = 1'b1; end
            4'd4:             c.data = 8'hFB;
            4'd5, 4'd7:       begin c.data = 8'h00; c.stop = 1'b1; end
            4'd8:             begin c.start = 1'b1; c.data = {JP_DEV, 1'b1}; end
            4'd14:            begin c.rd = 1'b1; c.stop = 1'b1; end
            default:          begin c.rd = 1'b1; c.ack = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/jpoll_bit_engine.sv
module jpoll_bit_engine
    import jpoll_pkg::*;
#(
    parameter int unsigned QTR_CLKS = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  jp_cmd_t    cmd_i,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_low_o,
    output logic       done_o,
    output logic       nack_o,
    output logic [7:0] rx_o
);

    localparam int unsigned QW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;

    typedef struct packed {
        eng_st_t       st;
        logic [QW-1:0] qc;
        logic [1:0]    ph;
        logic [3:0]    bn;
        logic [7:0]    sh;
        jp_cmd_t       cmd;
        logic          scl;
        logic          low;
        logic          held;
        logic          ackbit;
        logic          done;
        logic          nack;
    } eng_t;

    eng_t eng_q, eng_d;
    logic tick;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        tick       = (eng_q.qc == QW'(QTR_CLKS - 1));
        if (eng_q.st != E_IDLE) begin
            eng_d.qc = tick ? '0 : eng_q.qc + 1'b1;
        end
        case (eng_q.st)
            E_IDLE: begin
                if (go_i) begin
                    eng_d.cmd  = cmd_i;
                    eng_d.sh   = cmd_i.data;
                    eng_d.qc   = '0;
                    eng_d.ph   = 2'd0;
                    eng_d.bn   = 4'd0;
                    eng_d.nack = 1'b0;
                    if (cmd_i.start) begin
                        eng_d.st  = E_START;
                        eng_d.low = 1'b0;
                    end else begin
                        eng_d.st = E_BIT;
                    end
                end
            end
            E_START: begin
                if (tick) begin
                    eng_d.ph = eng_q.ph + 2'd1;
                    case (eng_q.ph)
                        2'd0: eng_d.scl = 1'b1;
                        2'd1: eng_d.low = 1'b1;   // START: SDA falls, SCL high
                        2'd2: eng_d.scl = 1'b0;
                        default: eng_d.st = E_BIT;
                    endcase
                end
            end
            E_BIT: begin
                if (tick) begin
                    eng_d.ph = eng_q.ph + 2'd1;
                    case (eng_q.ph)
                        2'd0: begin
                            if (eng_q.bn != 4'd8) begin
                                eng_d.low = !eng_q.cmd.rd && !eng_q.sh[7];
                            end else begin
                                eng_d.low = eng_q.cmd.rd && eng_q.cmd.ack;
                            end
                        end
                        2'd1: eng_d.scl = 1'b1;
                        2'd2: begin   // middle of SCL high
                            if (eng_q.bn != 4'd8) begin
                                eng_d.sh = {eng_q.sh[6:0], sda_i};
                            end else begin
                                eng_d.ackbit = sda_i;
                            end
                        end
                        default: begin
                            eng_d.scl = 1'b0;
                            if (eng_q.bn != 4'd8) begin
                                eng_d.bn = eng_q.bn + 4'd1;
                            end else begin
                                eng_d.nack = !eng_q.cmd.rd && eng_q.ackbit;
                                if (eng_q.cmd.stop || (!eng_q.cmd.rd && eng_q.ackbit)) begin
                                    eng_d.st = E_STOP;
                                end else begin
                                    eng_d.st   = E_IDLE;
                                    eng_d.held = 1'b1;
                                    eng_d.done = 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
            default: begin   // E_STOP
                if (tick) begin
                    eng_d.ph = eng_q.ph + 2'd1;
                    case (eng_q.ph)
                        2'd0: eng_d.low = 1'b1;
                        2'd1: eng_d.scl = 1'b1;
                        2'd2: eng_d.low = 1'b0;   // STOP: SDA rises, SCL high
                        default: begin
                            eng_d.st   = E_IDLE;
                            eng_d.held = 1'b0;
                            eng_d.done = 1'b1;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q     <= '0;
            eng_q.st  <= E_IDLE;
            eng_q.scl <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign scl_o     = eng_q.scl;
    assign sda_low_o = eng_q.low;
    assign done_o    = eng_q.done;
    assign nack_o    = eng_q.nack;
    assign rx_o      = eng_q.sh;

    // R10: during data and acknowledge bits SDA holds while SCL is high
    p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == E_BIT && eng_q.scl && $past(eng_q.scl)) |-> $stable(eng_q.low));

    // R1: a bus not held by a transaction is released with SCL high
    p_bus_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == E_IDLE && !eng_q.held) |-> (eng_q.scl && !eng_q.low));

endmodule

// File: rtl/jpoll_seq.sv
module jpoll_seq
    import jpoll_pkg::*;
#(
    parameter int unsigned WAIT_CLKS    = 100_000,
    parameter int unsigned GAP_CLKS     = 1_000_000,
    parameter int unsigned BACKOFF_CLKS = 5_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eng_done_i,
    input  logic                eng_nack_i,
    input  logic [7:0]          eng_rx_i,
    output logic                go_o,
    output jp_cmd_t             cmd_o,
    output logic [JP_RPT_W-1:0] rpt_o,
    output logic                upd_o,
    output logic                err_o
);

    localparam int unsigned T_A  = (WAIT_CLKS > GAP_CLKS) ? WAIT_CLKS : GAP_CLKS;
    localparam int unsigned T_MX = (T_A > BACKOFF_CLKS) ? T_A : BACKOFF_CLKS;
    localparam int unsigned TW   = $clog2(T_MX + 1);

    typedef struct packed {
        seq_st_t             st;
        logic [3:0]          step;
        logic [TW-1:0]       tmr;
        logic [JP_RPT_W-1:0] rpt;
        logic                go;
        logic                upd;
        logic                err;
    } seq_t;

    seq_t seq_q, seq_d;
    jp_cmd_t cur;

    always_comb begin
        cur       = jp_step_cmd(seq_q.step);
        seq_d     = seq_q;
        seq_d.go  = 1'b0;
        seq_d.upd = 1'b0;
        case (seq_q.st)
            S_ISSUE: begin
                seq_d.go = 1'b1;
                seq_d.st = S_BUSY;
            end
            S_BUSY: begin
                if (eng_done_i) begin
                    if (eng_nack_i) begin
                        seq_d.err  = 1'b1;
                        seq_d.st   = S_BACKOFF;
                        seq_d.tmr  = '0;
                        seq_d.step = 4'd0;
                    end else begin
                        if (cur.rd) begin
                            seq_d.rpt = {seq_q.rpt[JP_RPT_W-9:0], eng_rx_i};
                        end
                        if (seq_q.step == ST_PTR_LAST) begin
                            seq_d.st   = S_DELAY;
                            seq_d.tmr  = '0;
                            seq_d.step = ST_RD_ADDR;
                        end else if (seq_q.step == ST_RD_LAST) begin
                            seq_d.upd  = 1'b1;
                            seq_d.st   = S_GAP;
                            seq_d.tmr  = '0;
                            seq_d.step = ST_POLL;
                        end else begin
                            seq_d.step = seq_q.step + 4'd1;
                            seq_d.st   = S_ISSUE;
                        end
                    end
                end
            end
            S_DELAY: begin
                if (seq_q.tmr == TW'(WAIT_CLKS - 1)) seq_d.st = S_ISSUE;
                else seq_d.tmr = seq_q.tmr + 1'b1;
            end
            S_GAP: begin
                if (seq_q.tmr == TW'(GAP_CLKS - 1)) seq_d.st = S_ISSUE;
                else seq_d.tmr = seq_q.tmr + 1'b1;
            end
            default: begin   // S_BACKOFF
                if (seq_q.tmr == TW'(BACKOFF_CLKS - 1)) seq_d.st = S_ISSUE;
                else seq_d.tmr = seq_q.tmr + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= S_ISSUE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign go_o  = seq_q.go;
    assign cmd_o = cur;
    assign rpt_o = seq_q.rpt;
    assign upd_o = seq_q.upd;
    assign err_o = seq_q.err;

    // R9: a refused byte sends the sequencer into back-off with the flag set
    p_nack_backoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_BUSY && eng_done_i && eng_nack_i) |=> (seq_q.st == S_BACKOFF && seq_q.err));

    // R3: the post-pointer delay is not cut short
    p_delay_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_DELAY && seq_q.tmr != TW'(WAIT_CLKS - 1)) |=> (seq_q.st == S_DELAY));

    // R8: an update only follows the last read byte
    p_upd_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.upd |-> (seq_q.st == S_GAP && $past(seq_q.step) == ST_RD_LAST));

endmodule

// File: rtl/jpoll_unpack.sv
module jpoll_unpack
    import jpoll_pkg::*;
(
    input  logic [JP_RPT_W-1:0] rpt_i,
    output logic [7:0]          jx_o,
    output logic [7:0]          jy_o,
    output logic [2:0][9:0]     acc_o,
    output logic                bc_o,
    output logic                bz_o
);

    // received byte k sits at rpt_i[47-8k -: 8]
    assign jx_o = rpt_i[JP_RPT_W-1 -: 8];
    assign jy_o = rpt_i[JP_RPT_W-9 -: 8];

    for (genvar g = 0; g < 3; g++) begin : g_axis
        assign acc_o[g] = {rpt_i[JP_RPT_W-1-8*(2+g) -: 8], rpt_i[2*g+3 -: 2]};
    end

    assign bc_o = !rpt_i[1];
    assign bz_o = !rpt_i[0];

endmodule

// File: rtl/joy_poller.sv
module joy_poller
    import jpoll_pkg::*;
#(
    parameter int unsigned QTR_CLKS     = 250,
    parameter int unsigned WAIT_CLKS    = 100_000,
    parameter int unsigned GAP_CLKS     = 1_000_000,
    parameter int unsigned BACKOFF_CLKS = 5_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       scl_o,
    output logic       sda_pull_o,
    input  logic       sda_i,
    output logic [7:0] joy_x_o,
    output logic [7:0] joy_y_o,
    output logic [9:0] accel_x_o,
    output logic [9:0] accel_y_o,
    output logic [9:0] accel_z_o,
    output logic       btn_c_o,
    output logic       btn_z_o,
    output logic       report_vld_o,
    output logic       nack_err_o
);

    logic                go, eng_done, eng_nack, upd, err;
    logic [7:0]          eng_rx;
    jp_cmd_t             cmd;
    logic [JP_RPT_W-1:0] rpt;
    logic [7:0]          u_jx, u_jy;
    logic [2:0][9:0]     u_acc;
    logic                u_bc, u_bz;

    jpoll_bit_engine #(.QTR_CLKS(QTR_CLKS)) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .cmd_i     (cmd),
        .sda_i     (sda_i),
        .scl_o     (scl_o),
        .sda_low_o (sda_pull_o),
        .done_o    (eng_done),
        .nack_o    (eng_nack),
        .rx_o      (eng_rx)
    );

    jpoll_seq #(
        .WAIT_CLKS    (WAIT_CLKS),
        .GAP_CLKS     (GAP_CLKS),
        .BACKOFF_CLKS (BACKOFF_CLKS)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_done_i (eng_done),
        .eng_nack_i (eng_nack),
        .eng_rx_i   (eng_rx),
        .go_o       (go),
        .cmd_o      (cmd),
        .rpt_o      (rpt),
        .upd_o      (upd),
        .err_o      (err)
    );

    jpoll_unpack unpack_i (
        .rpt_i (rpt),
        .jx_o  (u_jx),
        .jy_o  (u_jy),
        .acc_o (u_acc),
        .bc_o  (u_bc),
        .bz_o  (u_bz)
    );

    typedef struct packed {
        logic [7:0]      jx;
        logic [7:0]      jy;
        logic [2:0][9:0] acc;
        logic            bc;
        logic            bz;
        logic            vld;
    } out_t;

    out_t out_q, out_d;

    always_comb begin
        out_d     = out_q;
        out_d.vld = upd;
        if (upd) begin
            out_d.jx  = u_jx;
            out_d.jy  = u_jy;
            out_d.acc = u_acc;
            out_d.bc  = u_bc;
            out_d.bz  = u_bz;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign joy_x_o      = out_q.jx;
    assign joy_y_o      = out_q.jy;
    assign accel_x_o    = out_q.acc[0];
    assign accel_y_o    = out_q.acc[1];
    assign accel_z_o    = out_q.acc[2];
    assign btn_c_o      = out_q.bc;
    assign btn_z_o      = out_q.bz;
    assign report_vld_o = out_q.vld;
    assign nack_err_o   = err;

    // R8: the strobe lasts one cycle
    p_vld_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        report_vld_o |=> !report_vld_o);

    // R8: report outputs move only with an update
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable({joy_x_o, joy_y_o, accel_x_o, accel_y_o, accel_z_o, btn_c_o, btn_z_o}));

    // R9: the error flag never clears outside reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nack_err_o |=> nack_err_o);

endmodule

// File: tb/joy_poller_tb.sv
module joy_poller_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 2;
    localparam int WAITC      = 40;
    localparam int GAPC       = 20;
    localparam int BACKC      = 60;
    localparam int NPOLL      = 40;
    localparam int WD_CYCLES  = 120_000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl, sda_pull, sda_i;
    logic [7:0] jx, jy;
    logic [9:0] ax, ay, az;
    logic       bc, bz, vld, err;
    logic       slv_low = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign sda_i = !(sda_pull || slv_low);

    joy_poller #(
        .QTR_CLKS(QTR), .WAIT_CLKS(WAITC), .GAP_CLKS(GAPC), .BACKOFF_CLKS(BACKC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_o(scl), .sda_pull_o(sda_pull), .sda_i(sda_i),
        .joy_x_o(jx), .joy_y_o(jy), .accel_x_o(ax), .accel_y_o(ay), .accel_z_o(az),
        .btn_c_o(bc), .btn_z_o(bz), .report_vld_o(vld), .nack_err_o(err)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] rep [6];
    logic [7:0] sent [6];
    logic [7:0] txbuf [6];
    logic [7:0] wlog [256];
    int         stoplog [256];
    int wcnt = 0, nstop = 0, cyc = 0, rd_done = 0;
    int t_start = 0, t_last_stop = 0, t_nack_stop = 0, last_gap = 0, bo_gap = 0;
    bit pend_bo = 0;
    logic [5:0] last_macks;
    int last_rdn = 0;
    bit nack_addr_once = 0, nack_byte_en = 0;
    logic [7:0] nack_byte = 8'h00;

    initial begin
        int cnt = 0, mode = 0, txi = 0;
        bit in_txn = 0, first = 0, was_read = 0, had_nack = 0, nackd = 0;
        bit prev_scl = 1, prev_line = 1, line, s, nk;
        logic [7:0] sh = 0;
        logic [5:0] mv = 0;
        logic mack = 1;
        forever begin
            @(negedge clk);
            cyc++;
            line = sda_i;
            s = scl;
            if (prev_scl && s && prev_line && !line) begin
                in_txn = 1; mode = 1; cnt = 0; first = 1; was_read = 0;
                had_nack = 0; nackd = 0; t_start = cyc; mv = 0;
                if (pend_bo) begin bo_gap = cyc - t_nack_stop; pend_bo = 0; end
            end else if (prev_scl && s && !prev_line && line) begin
                if (in_txn) begin
                    if (nstop < 256) stoplog[nstop] = wcnt;
                    nstop++;
                    t_last_stop = cyc;
                    if (was_read) begin last_macks = mv; last_rdn = txi + 1; rd_done++; end
                    if (had_nack) begin t_nack_stop = cyc; pend_bo = 1; end
                end
                in_txn = 0; mode = 0; slv_low = 0;
            end else if (in_txn && !prev_scl && s && mode != 0) begin
                if (cnt < 8 && mode == 1) sh = {sh[6:0], line};
                if (cnt == 8 && mode == 2) begin mack = line; mv[txi] = line; end
                cnt++;
            end else if (in_txn && prev_scl && !s) begin
                if (mode == 1) begin
                    if (cnt == 8) begin
                        nk = (first && nack_addr_once) || (!first && nack_byte_en && sh == nack_byte);
                        if (nk && first) nack_addr_once = 0;
                        else if (nk) nack_byte_en = 0;
                        if (wcnt < 256) wlog[wcnt] = sh;
                        wcnt++;
                        if (first && sh == 8'hA5) last_gap = t_start - t_last_stop;
                        slv_low = !nk;
                        if (nk) begin had_nack = 1; nackd = 1; end
                    end else if (cnt == 9) begin
                        slv_low = 0; cnt = 0;
                        if (nackd) mode = 0;
                        else if (first && sh[0]) begin
                            mode = 2; was_read = 1; txi = 0;
                            for (int k = 0; k < 6; k++) begin txbuf[k] = rep[k]; sent[k] = rep[k]; end
                            slv_low = !txbuf[0][7];
                        end
                        first = 0;
                    end
                end else if (mode == 2) begin
                    if (cnt >= 1 && cnt <= 7) slv_low = !txbuf[txi][7 - cnt];
                    else if (cnt == 8) slv_low = 0;
                    else if (cnt == 9) begin
                        cnt = 0;
                        if (!mack && txi < 5) begin txi++; slv_low = !txbuf[txi][7]; end
                        else begin mode = 0; slv_low = 0; end
                    end
                end
            end
            prev_scl = s; prev_line = line;
        end
    end

    // ---------------- stimulus and checks ----------------
    function automatic logic [7:0] pat(input int i, input int k);
        if (i == 0) return 8'h00;
        if (i == 1) return 8'hFF;
        if (k == 5) return 8'(i * 53 + 7);
        return 8'(i * (17 + k * 12) + k * 41 + 3);
    endfunction

    task automatic set_rep(input int i);
        for (int k = 0; k < 6; k++) rep[k] = pat(i, k);
    endtask

    task automatic wait_vld();
        do @(negedge clk); while (!vld);
    endtask

    int nvalid = 0;

    task automatic check_report();
        logic [7:0] b5;
        logic [7:0] s_jx, s_jy;
        logic [9:0] s_ax, s_ay, s_az;
        logic s_bc, s_bz;
        int ex, ey, ez;
        b5 = sent[5];
        ex = sent[2] * 4 + ((b5 >> 2) & 3);
        ey = sent[3] * 4 + ((b5 >> 4) & 3);
        ez = sent[4] * 4 + ((b5 >> 6) & 3);
        nvalid++;
        chk(jx == sent[0], "R5", "joy x", jx, sent[0]);
        chk(jy == sent[1], "R5", "joy y", jy, sent[1]);
        chk(ax == 10'(ex), "R6", "accel x", ax, ex);
        chk(ay == 10'(ey), "R6", "accel y", ay, ey);
        chk(az == 10'(ez), "R6", "accel z", az, ez);
        chk(bc == (((b5 >> 1) & 1) == 0), "R7", "button c", bc, ((b5 >> 1) & 1) == 0);
        chk(bz == ((b5 & 1) == 0), "R7", "button z", bz, (b5 & 1) == 0);
        chk(last_macks == 6'b100000, "R4", "master ack pattern", last_macks, 6'b100000);
        chk(last_rdn == 6, "R4", "bytes read", last_rdn, 6);
        chk(last_gap >= WAITC && last_gap <= WAITC + 4 * QTR + 6, "R3", "pointer-to-read gap",
            last_gap, WAITC);
        chk(rd_done == nvalid, "R8", "strobes per read", nvalid, rd_done);
        s_jx = jx; s_jy = jy; s_ax = ax; s_ay = ay; s_az = az; s_bc = bc; s_bz = bz;
        repeat (5) @(negedge clk);
        chk(!vld, "R8", "strobe width", vld, 0);
        chk({jx, jy, ax, ay, az, bc, bz} == {s_jx, s_jy, s_ax, s_ay, s_az, s_bc, s_bz},
            "R8", "outputs held", {jx, jy}, {s_jx, s_jy});
    endtask

    task automatic chk_log(input int idx, input logic [7:0] exp, input string tag);
        chk(wlog[idx] == exp, tag, $sformatf("written byte %0d", idx), wlog[idx], exp);
    endtask

    initial begin
        int idx0, ns0;
        rst_n = 1'b0;
        set_rep(0);
        repeat (3) @(negedge clk);
        chk(scl == 1'b1, "R1", "scl in reset", scl, 1);
        chk(sda_pull == 1'b0, "R1", "sda in reset", sda_pull, 0);
        chk(!vld && !err, "R1", "strobe and flag in reset", {vld, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl == 1'b1 && sda_pull == 1'b0, "R1", "bus after reset", {scl, sda_pull}, 2'b10);

        for (int i = 0; i < NPOLL; i++) begin
            wait_vld();
            check_report();
            if (i == 0) begin
                // R2 wake-up writes, R3 first pointer write
                chk_log(0, 8'hA4, "R2"); chk_log(1, 8'hF0, "R2"); chk_log(2, 8'h55, "R2");
                chk_log(3, 8'hA4, "R2"); chk_log(4, 8'hFB, "R2"); chk_log(5, 8'h00, "R2");
                chk_log(6, 8'hA4, "R3"); chk_log(7, 8'h00, "R3"); chk_log(8, 8'hA5, "R3");
                chk(stoplog[0] == 3, "R2", "first stop", stoplog[0], 3);
                chk(stoplog[1] == 6, "R2", "second stop", stoplog[1], 6);
                chk(stoplog[2] == 8, "R3", "pointer stop", stoplog[2], 8);
            end
            set_rep(i + 1);
        end
        chk(!err, "R9", "no flag before refusal", err, 0);

        // R9: refuse the next address, then the 0xF0 of the re-wake
        idx0 = wcnt; ns0 = nstop;
        nack_byte = 8'hF0; nack_byte_en = 1; nack_addr_once = 1;
        do @(negedge clk); while (!err);
        chk(err, "R9", "flag raised", err, 1);
        wait_vld();
        check_report();
        chk_log(idx0 + 0, 8'hA4, "R9"); chk_log(idx0 + 1, 8'hA4, "R9");
        chk_log(idx0 + 2, 8'hF0, "R9"); chk_log(idx0 + 3, 8'hA4, "R9");
        chk_log(idx0 + 4, 8'hF0, "R9"); chk_log(idx0 + 5, 8'h55, "R9");
        chk_log(idx0 + 6, 8'hA4, "R9"); chk_log(idx0 + 7, 8'hFB, "R9");
        chk_log(idx0 + 8, 8'h00, "R9"); chk_log(idx0 + 11, 8'hA5, "R9");
        chk(stoplog[ns0] == idx0 + 1, "R9", "stop after refused address", stoplog[ns0], idx0 + 1);
        chk(stoplog[ns0 + 1] == idx0 + 3, "R9", "stop after refused data", stoplog[ns0 + 1], idx0 + 3);
        chk(bo_gap >= BACKC, "R9", "back-off length", bo_gap, BACKC);
        chk(err, "R9", "flag sticky", err, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule